// File: doc/BRIEF.md
# Interlocked Bus Memory Slave

This block is a memory responder on a local execution bus that uses an interlocked, fully handshaken transfer. A master holds an address on the bus with an address-valid qualifier, then raises a data strobe. When the address falls inside the slave's configured window, the slave performs the access on its internal byte-laned 16-bit memory. It then raises acknowledge and holds it until the master drops the data strobe.

The slave alone sets the access time. On a write, acknowledge comes only after the data has been committed to the array. On a read, acknowledge comes together with the read word, which the slave drives onto the data lines. A latency parameter stretches the access, so that slaves of different speeds can share one bus and be told apart in tests.

Several such slaves, up to four, can sit on one bus with disjoint windows. Outside its window the slave stays silent: it raises no acknowledge and enables no data drivers.

Top module: `lbMemSlave`

## Requirements
- R1: The slave starts an access only when `addrValid` and `dataStrobe` are both high and `busAddr` lies in [BASE, BASE+SIZE). Any other address never raises `ack` or `rdDataOe`.
- R2: When `addrValid`, `dataStrobe` and an in-window address appear together at an idle slave, `ack` rises on the (LATENCY+2)-th rising clock edge that samples the strobe high, counting the first sampling edge as edge 1.
- R3: Write data is stored in the array before `ack` rises, so a later read of the same location returns it.
- R4: Write byte lanes are selected by {`byteHighEn`, `busAddr[0]`]:
  - 10 writes the full word.
  - 00 writes the low byte from `wrData[7:0]`.
  - 11 writes the high byte from `wrData[15:8]`.
  - 01 writes the high byte from `wrData[7:0]`.
- R5: A read returns the full word at the even address, except for the code {`byteHighEn`,`busAddr[0]`}=01. That code returns {8'h00, high byte}.
- R6: `rdDataOe` is high only while `ack` is high during a read, and never during a write. `rdData` is zero whenever `rdDataOe` is low.
- R7: `ack` stays high for as long as `dataStrobe` stays high, and falls on the first clock edge that samples `dataStrobe` low.
- R8: While `rstN` is low, and right after reset, `ack` and `rdDataOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address from the master |
| addrValid | input | 1 | Address and status qualifier |
| dataStrobe | input | 1 | Data strobe; high for the whole transfer |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| byteHighEn | input | 1 | High byte lane enable |
| wrData | input | 16 | Write data from the master |
| rdData | output | 16 | Read data, zero when not driven |
| rdDataOe | output | 1 | Read data output enable |
| ack | output | 1 | Transfer acknowledge |

## Verification
The array commit of a write and the acknowledge that reports it fall on adjacent edges. The write commits on the edge that leaves the access state, and `ack` is visible right after it. A read issued immediately after the write therefore checks that storage really happened before acknowledge. The bench provokes this with back-to-back write then read transfers to the same word, including partial-lane writes. It judges the result with a byte-level model of the memory and a measured acknowledge latency of LATENCY+2 edges.

// File: rtl/lbSlvPkg.sv
package lbSlvPkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DO,
    ST_HOLD
  } slvState_t;

  typedef struct packed {
    logic wrEn;
    logic rdLoad;
  } dpCtrl_t;
endpackage

// File: rtl/lbSlvCtrl.sv
module lbSlvCtrl
  import lbSlvPkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrValid,
  input  logic    dataStrobe,
  input  logic    readNotWrite,
  input  logic    hit,
  output dpCtrl_t dpCtrl,
  output logic    ack,
  output logic    rdDataOe
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

  slvState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic             isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      isRead  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (addrValid && dataStrobe && hit) begin
          state   <= ST_WAIT;
          waitCnt <= '0;
          isRead  <= readNotWrite;
        end
        ST_WAIT: begin
          if (waitCnt == CNT_LAST) state <= ST_DO;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_DO:   state <= ST_HOLD;
        ST_HOLD: if (!dataStrobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.wrEn   = (state == ST_DO) && !isRead;
    dpCtrl.rdLoad = (state == ST_DO) && isRead;
    ack           = (state == ST_HOLD);
    rdDataOe      = (state == ST_HOLD) && isRead;
  end
endmodule

// File: rtl/lbSlvDatapath.sv
module lbSlvDatapath
  import lbSlvPkg::*;
#(
  parameter int                ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE   = 24'h001000,
  parameter int                SIZE   = 256
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              byteHighEn,
  input  logic [DATA_W-1:0] wrData,
  input  dpCtrl_t           dpCtrl,
  output logic              hit,
  output logic [DATA_W-1:0] rdWord
);
  localparam int WORDS = SIZE / 2;
  localparam int IDX_W = (WORDS < 2) ? 1 : $clog2(WORDS);
  localparam logic [ADDR_W:0] LOW_LIM  = {1'b0, BASE};
  localparam logic [ADDR_W:0] HIGH_LIM = LOW_LIM + (ADDR_W+1)'(SIZE);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W:0]    offset;
  logic [IDX_W-1:0]  idx;
  logic              lowLane;
  logic              highLane;
  logic [BYTE_W-1:0] highByteIn;
  logic              swapRead;

  assign hit    = ({1'b0, busAddr} >= LOW_LIM) && ({1'b0, busAddr} < HIGH_LIM);
  assign offset = busAddr[IDX_W:0] - BASE[IDX_W:0];
  assign idx    = IDX_W'(offset >> 1);

  assign lowLane    = !busAddr[0];
  assign highLane   = byteHighEn || busAddr[0];
  assign highByteIn = (busAddr[0] && !byteHighEn) ? wrData[BYTE_W-1:0]
                                                  : wrData[DATA_W-1:BYTE_W];
  assign swapRead   = busAddr[0] && !byteHighEn;

  always_ff @(posedge clk) begin
    if (dpCtrl.wrEn) begin
      if (lowLane)  mem[idx][BYTE_W-1:0]      <= wrData[BYTE_W-1:0];
      if (highLane) mem[idx][DATA_W-1:BYTE_W] <= highByteIn;
    end
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.rdLoad) begin
      rdWord <= swapRead ? {{BYTE_W{1'b0}}, mem[idx][DATA_W-1:BYTE_W]} : mem[idx];
    end
  end
endmodule

// File: rtl/lbMemSlave.sv
module lbMemSlave
  import lbSlvPkg::*;
#(
  parameter int                ADDR_W  = 24,
  parameter logic [ADDR_W-1:0] BASE    = 24'h001000,
  parameter int                SIZE    = 256,
  parameter int                LATENCY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              addrValid,
  input  logic              dataStrobe,
  input  logic              readNotWrite,
  input  logic              byteHighEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              rdDataOe,
  output logic              ack
);
  dpCtrl_t           dpCtrl;
  logic              hit;
  logic [DATA_W-1:0] rdWord;
  logic              oeInt;

  lbSlvCtrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .dataStrobe(dataStrobe),
    .readNotWrite(readNotWrite), .hit(hit), .dpCtrl(dpCtrl),
    .ack(ack), .rdDataOe(oeInt)
  );

  lbSlvDatapath #(.ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE)) dp_i (
    .clk(clk), .busAddr(busAddr), .byteHighEn(byteHighEn), .wrData(wrData),
    .dpCtrl(dpCtrl), .hit(hit), .rdWord(rdWord)
  );

  assign rdDataOe = oeInt;
  assign rdData   = oeInt ? rdWord : '0;
endmodule

// File: rtl/lbMemSlave_chk.sv
module lbMemSlave_chk #(
  parameter int                ADDR_W  = 24,
  parameter logic [ADDR_W-1:0] BASE    = 24'h001000,
  parameter int                SIZE    = 256,
  parameter int                LATENCY = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              dataStrobe,
  input logic              readNotWrite,
  input logic [15:0]       rdData,
  input logic              rdDataOe,
  input logic              ack
);
  logic [7:0] strobeCnt;
  logic       inWin;

  assign inWin = (32'(busAddr) >= 32'(BASE)) && (32'(busAddr) < 32'(BASE) + 32'(SIZE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeCnt <= '0;
    else if (!dataStrobe) strobeCnt <= '0;
    else if (strobeCnt != 8'hFF) strobeCnt <= strobeCnt + 1'b1;
  end

  // R1
  ack_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> inWin);

  // R2
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> (strobeCnt == 8'(LATENCY + 2)));

  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDataOe |-> (ack && readNotWrite));

  // R6
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe |-> (rdData == 16'h0000));

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !dataStrobe) |=> !ack);

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && dataStrobe) |=> ack);
endmodule

bind lbMemSlave lbMemSlave_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE), .LATENCY(LATENCY)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .dataStrobe(dataStrobe),
  .readNotWrite(readNotWrite), .rdData(rdData), .rdDataOe(rdDataOe), .ack(ack)
);

// File: tb/lbMemSlave_tb_top.sv
module lbMemSlave_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          LAT        = 3;
  localparam logic [23:0] BASE       = 24'h001000;
  localparam int          SIZE       = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic        addrValid = 1'b0;
  logic        dataStrobe = 1'b0;
  logic        readNotWrite = 1'b0;
  logic        byteHighEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdDataOe;
  logic        ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbMemSlave #(.ADDR_W(24), .BASE(BASE), .SIZE(SIZE), .LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .addrValid(addrValid),
    .dataStrobe(dataStrobe), .readNotWrite(readNotWrite), .byteHighEn(byteHighEn),
    .wrData(wrData), .rdData(rdData), .rdDataOe(rdDataOe), .ack(ack)
  );

  typedef struct {
    bit          isRead;
    logic [15:0] data;
    string       req;
  } item_t;

  item_t      scb[$];
  logic [7:0] model[int];
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  logic       prevAck = 1'b0;
  bit         finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [23:0] a, input bit bhe);
    int w = int'(a) & ~1;
    if (a[0] && !bhe) return {8'h00, model[w+1]};
    return {model[w+1], model[w]};
  endfunction

  task automatic modelWrite(input logic [23:0] a, input bit bhe, input logic [15:0] wd);
    int w = int'(a) & ~1;
    case ({bhe, a[0]})
      2'b10: begin model[w] = wd[7:0]; model[w+1] = wd[15:8]; end
      2'b00: model[w] = wd[7:0];
      2'b11: model[w+1] = wd[15:8];
      default: model[w+1] = wd[7:0];
    endcase
  endtask

  // Monitor: pops expectations when acknowledge rises
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        cyc = 0;
        prevAck = 1'b0;
      end else begin
        cyc = dataStrobe ? cyc + 1 : 0;
        if (ack && !prevAck) begin
          if (scb.size() == 0) begin
            check(1'b0, "R1", "unexpected ack", 32'd1, 32'd0);
          end else begin
            it = scb.pop_front();
            check(cyc == LAT + 2, "R2", "ack latency", 32'(cyc), 32'(LAT + 2));
            if (it.isRead)
              check(rdDataOe && rdData == it.data, it.req, "read data",
                    {15'd0, rdDataOe, rdData}, {15'd0, 1'b1, it.data});
            else
              check(!rdDataOe && rdData == 16'h0, "R6", "no drive on write",
                    {15'd0, rdDataOe, rdData}, 32'd0);
          end
        end
        prevAck = ack;
      end
    end
  end

  task automatic access(input bit rd, input logic [23:0] a, input bit bhe,
                        input logic [15:0] wd, input bit expectHit, input string req);
    item_t it;
    int    waited;
    bit    quiet;
    @(negedge clk); #1;
    busAddr = a; readNotWrite = rd; byteHighEn = bhe; wrData = wd;
    addrValid = 1'b1; dataStrobe = 1'b1;
    if (expectHit) begin
      it.isRead = rd;
      it.data = rd ? expRead(a, bhe) : 16'h0;
      it.req = req;
      scb.push_back(it);
      if (!rd) modelWrite(a, bhe, wd);
      waited = 0;
      do begin
        @(negedge clk);
        waited++;
      end while (!ack && waited < 40);
      check(ack == 1'b1, req, "ack seen", {31'd0, ack}, 32'd1);
      @(negedge clk);
      check(ack == 1'b1, "R7", "ack held with strobe", {31'd0, ack}, 32'd1);
      #1;
      dataStrobe = 1'b0; addrValid = 1'b0;
      @(negedge clk);
      check(!ack && !rdDataOe, "R7", "ack released", {30'd0, ack, rdDataOe}, 32'd0);
    end else begin
      quiet = 1'b1;
      repeat (LAT + 6) begin
        @(negedge clk);
        if (ack || rdDataOe) quiet = 1'b0;
      end
      check(quiet, "R1", "miss stays silent", {31'd0, !quiet}, 32'd0);
      #1;
      dataStrobe = 1'b0; addrValid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!ack && !rdDataOe, "R8", "reset outputs", {30'd0, ack, rdDataOe}, 32'd0);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!ack && !rdDataOe && rdData == 16'h0, "R8", "after reset",
          {14'd0, ack, rdDataOe, rdData}, 32'd0);

    // R3: full-word writes then read back
    for (int i = 0; i < 8; i += 2)
      access(1'b0, BASE + 24'(i), 1'b1, 16'hA500 + 16'(i * 17), 1'b1, "R3");
    for (int i = 0; i < 8; i += 2)
      access(1'b1, BASE + 24'(i), 1'b1, 16'h0, 1'b1, "R3");

    // R4: partial byte lanes, each followed at once by a read
    access(1'b0, BASE + 24'd2, 1'b0, 16'hFF3C, 1'b1, "R4");
    access(1'b1, BASE + 24'd2, 1'b1, 16'h0, 1'b1, "R4");
    access(1'b0, BASE + 24'd5, 1'b1, 16'h7E11, 1'b1, "R4");
    access(1'b1, BASE + 24'd4, 1'b1, 16'h0, 1'b1, "R4");
    access(1'b0, BASE + 24'd7, 1'b0, 16'h2299, 1'b1, "R4");
    access(1'b1, BASE + 24'd6, 1'b1, 16'h0, 1'b1, "R4");

    // R5: odd address with low lane returns the high byte
    access(1'b1, BASE + 24'd7, 1'b0, 16'h0, 1'b1, "R5");
    access(1'b1, BASE + 24'd5, 1'b1, 16'h0, 1'b1, "R5");

    // R1: window edges
    access(1'b0, BASE + 24'(SIZE - 2), 1'b1, 16'hC0DE, 1'b1, "R1");
    access(1'b1, BASE + 24'(SIZE - 1), 1'b1, 16'h0, 1'b1, "R1");
    access(1'b1, BASE - 24'd1, 1'b1, 16'h0, 1'b0, "R1");
    access(1'b0, BASE + 24'(SIZE), 1'b1, 16'hDEAD, 1'b0, "R1");
    access(1'b1, BASE + 24'(SIZE), 1'b1, 16'h0, 1'b0, "R1");
    access(1'b1, BASE, 1'b1, 16'h0, 1'b1, "R3");

    check(scb.size() == 0, "R2", "all expected acks seen", 32'(scb.size()), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule